// File: doc/BRIEF.md
# Cache Data Array Debug Access Port

This block gives privileged, secure software direct access to individual entries of the level-one cache data RAMs. The data side and the instruction side each have their own array. Software does not address an array directly. It first loads a pair of staging registers: a 32-bit data word and a narrow sideband word that carries the dirty, dirty-parity and data-parity bits. It then writes an entry address to a write-command register, which copies both staging registers into that entry. To read, it writes an entry address to a read-command register. The entry is loaded into the staging registers, and software reads them back.

Requests arrive over a valid/ready register port. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops for the one cycle in which a read command's RAM data is moving into the staging registers, and the requester must hold the request until it is taken. Every request that is taken gets exactly one response beat on the next cycle. The response side has no back-pressure, so the requester must always be able to take it.

The dirty information is kept at doubleword granularity. The two words of an even/odd pair share one dirty bit and one dirty-parity bit. A write command to either word of the pair updates both.

Top module: `l1_array_dbg`

## Requirements
- R1: After reset, both staging registers of both sides hold zero, `rsp_valid`, `rsp_err` and `busy` are low and `req_ready` is high.
- R2: `req_reg[2]` picks the side (0 data, 1 instruction) and `req_reg[1:0]` picks the register: 0 staging word, 1 staging sideband (low SB_W bits, zero-extended on read), 2 write command, 3 read command. A write to a staging register reads back unchanged.
- R3: A write to the write-command register copies the staging word and the staging sideband into the entry addressed by `req_wdata`. The word offset is in bits [WORD_W-1:0], the set index is in the next SET_W bits, and the way is in the top WAY_W bits [31:32-WAY_W].
- R4: A write to the read-command register loads the addressed entry into both staging registers. `busy` is high for exactly the one cycle after the command is taken, and `req_ready` is low while `busy` is high. A staging read taken after that cycle returns the entry.
- R5: A command or staging access on one side leaves the other side's staging registers and array unchanged.
- R6: A request taken with `req_secure` or `req_priv` low changes no state. Its response has `rsp_err` high and `rsp_rdata` zero. `rsp_err` is low for every permitted request.
- R7: Sideband bit 0 is the dirty bit and bit 1 is its parity. Both are shared by an even/odd word pair (word offset bit 0 selects the word). A write command to either word sets these two bits for both words, and leaves the partner's data word and its sideband bits [SB_W-1:2] unchanged.
- R8: Each request taken in cycle N gives `rsp_valid` high in cycle N+1 only. A write request, or a read of a command register, returns `rsp_rdata` zero. A staging read returns the staging value as it stood before that cycle.
- R9: No request is taken while `req_ready` is low, and a request presented then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_reg | input | 3 | Side (bit 2) and register select (bits 1:0) |
| req_wdata | input | 32 | Write data or entry address |
| req_secure | input | 1 | Requester is in the secure state |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response beat, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes and denied requests |
| rsp_err | output | 1 | Request was denied by the privilege check |
| busy | output | 1 | A read command's data is landing in staging |

## Verification
The main function is tried with several address patterns. Entries are spread across every way and several sets, so a swapped or truncated address field sends data to the wrong entry and shows up on read-back. The same address is written on both sides with different data, which exposes any crosstalk between the two arrays. Writes to both words of a doubleword with different dirty values check whether the pair sharing works and whether the partner word and its parity bits stay intact. Requests with only one of the secure or privileged qualifiers set, and requests presented while a read is landing, check that denied or stalled requests leave the staging registers and arrays untouched.

// File: rtl/l1dbg_pkg.sv
package l1dbg_pkg;

  // Register select within one side, taken from req_reg[1:0]
  typedef enum logic [1:0] {
    FN_WORD = 2'd0,
    FN_SIDE = 2'd1,
    FN_WCMD = 2'd2,
    FN_RCMD = 2'd3
  } fn_e;

  localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/l1dbg_decode.sv
module l1dbg_decode
  import l1dbg_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_ready,
  input  logic [2:0] req_reg,
  input  logic       req_secure,
  input  logic       req_priv,
  output logic       take,
  output logic       allowed,
  output logic       side,
  output fn_e        fn
);

  always_comb begin
    take    = req_valid && req_ready;
    allowed = req_secure && req_priv;
    side    = req_reg[2];
    fn      = fn_e'(req_reg[1:0]);
  end

endmodule

// File: rtl/l1dbg_ram.sv
module l1dbg_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/l1dbg_side.sv
module l1dbg_side
  import l1dbg_pkg::*;
#(
  parameter int unsigned SB_W   = 4,
  parameter int unsigned WAY_W  = 2,
  parameter int unsigned SET_W  = 3,
  parameter int unsigned WORD_W = 3,
  localparam int unsigned ENT_W = WAY_W + SET_W + WORD_W,
  localparam int unsigned HI_W  = SB_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  fn_e             fn,
  input  logic [31:0]     wdata,
  output logic [31:0]     stage_word,
  output logic [SB_W-1:0] stage_sb,
  output logic            busy
);

  localparam int unsigned ENTRIES = 1 << ENT_W;
  localparam int unsigned PAIRS   = 1 << (ENT_W - 1);

  logic [ENT_W-1:0]   idx;
  logic [ENT_W-2:0]   pidx;
  logic               wcmd, rcmd, pend;
  logic [31+HI_W:0]   dat_q;
  logic [1:0]         dirty_q;

  // Entry index: way from the top bits, then set, then word offset
  assign idx  = {wdata[31 -: WAY_W], wdata[WORD_W +: SET_W], wdata[WORD_W-1:0]};
  assign pidx = idx[ENT_W-1:1];
  assign wcmd = sel && wr && (fn == FN_WCMD);
  assign rcmd = sel && wr && (fn == FN_RCMD);

  // Word plus upper sideband bits per entry
  l1dbg_ram #(.DW(32 + HI_W), .DEPTH(ENTRIES)) u_dat (
    .clk   (clk),
    .we    (wcmd),
    .re    (rcmd),
    .addr  (idx),
    .wdata ({stage_word, stage_sb[SB_W-1:2]}),
    .rdata (dat_q)
  );

  // Dirty and dirty-parity shared by each even/odd word pair
  l1dbg_ram #(.DW(2), .DEPTH(PAIRS)) u_dirty (
    .clk   (clk),
    .we    (wcmd),
    .re    (rcmd),
    .addr  (pidx),
    .wdata (stage_sb[1:0]),
    .rdata (dirty_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      stage_word <= '0;
      stage_sb   <= '0;
    end else begin
      pend <= rcmd;
      if (pend) begin
        stage_word <= dat_q[31+HI_W:HI_W];
        stage_sb   <= {dat_q[HI_W-1:0], dirty_q};
      end else if (sel && wr && fn == FN_WORD) begin
        stage_word <= wdata;
      end else if (sel && wr && fn == FN_SIDE) begin
        stage_sb <= wdata[SB_W-1:0];
      end
    end
  end

  assign busy = pend;

endmodule

// File: rtl/l1_array_dbg.sv
module l1_array_dbg
  import l1dbg_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 8,
  parameter int unsigned WORDS = 8,
  parameter int unsigned SB_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_reg,
  input  logic [31:0] req_wdata,
  input  logic        req_secure,
  input  logic        req_priv,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        busy
);

  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned WORD_W = $clog2(WORDS);

  logic take, allowed, side;
  fn_e  fn;

  logic [31:0]     st_word [NUM_SIDES];
  logic [SB_W-1:0] st_sb   [NUM_SIDES];
  logic [NUM_SIDES-1:0] side_busy;

  l1dbg_decode u_dec (
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_reg    (req_reg),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .take       (take),
    .allowed    (allowed),
    .side       (side),
    .fn         (fn)
  );

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    l1dbg_side #(
      .SB_W   (SB_W),
      .WAY_W  (WAY_W),
      .SET_W  (SET_W),
      .WORD_W (WORD_W)
    ) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (take && allowed && (side == 1'(g))),
      .wr         (req_write),
      .fn         (fn),
      .wdata      (req_wdata),
      .stage_word (st_word[g]),
      .stage_sb   (st_sb[g]),
      .busy       (side_busy[g])
    );
  end

  assign busy      = |side_busy;
  assign req_ready = !busy;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (allowed && !req_write) begin
      case (fn)
        FN_WORD: rd_mux = st_word[side];
        FN_SIDE: rd_mux = {{(32-SB_W){1'b0}}, st_sb[side]};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      rsp_err   <= take && !allowed;
      rsp_rdata <= take ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/l1_array_dbg_chk.sv
module l1_array_dbg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [2:0]  req_reg,
  input logic        req_secure,
  input logic        req_priv,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        busy
);

  logic taken, rd_cmd_ok;
  assign taken     = req_valid && req_ready;
  assign rd_cmd_ok = taken && req_write && (req_reg[1:0] == 2'd3) && req_secure && req_priv;

  // R4
  rd_cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_ok |=> busy);

  // R4
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R9
  busy_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R8
  rsp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> !rsp_valid);

  // R6
  denied_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !(req_secure && req_priv)) |=> (rsp_err && rsp_rdata == 32'd0));

  // R6
  allowed_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && req_secure && req_priv) |=> !rsp_err);

endmodule

bind l1_array_dbg l1_array_dbg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_reg    (req_reg),
  .req_secure (req_secure),
  .req_priv   (req_priv),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .busy       (busy)
);

// File: tb/l1_array_dbg_bench.sv
module l1_array_dbg_bench;

  localparam int SBW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
  logic [2:0]  req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, busy;
  logic [31:0] rsp_rdata;

  always #10 clk = ~clk;

  l1_array_dbg u_l1_array_dbg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_priv(req_priv), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [31:0]    m_word [2][256];
  logic [SBW-3:0] m_hi   [2][256];
  logic [1:0]     m_dty  [2][128];
  logic [31:0]    s_word [2];
  logic [SBW-1:0] s_sb   [2];
  logic           e_busy, p_side;
  logic [31:0]    p_word;
  logic [SBW-1:0] p_sb;
  logic           e_vld, e_err;
  logic [31:0]    e_rdata;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int ent(input logic [31:0] a);
    return int'({a[31:30], a[5:3], a[2:0]});
  endfunction

  task automatic step(input string tag, input logic v, input logic w, input logic [2:0] r,
                      input logic [31:0] d, input logic sec, input logic prv);
    logic acc, ok, sd, nb;
    logic [1:0] f;
    int i;
    req_valid = v; req_write = w; req_reg = r; req_wdata = d; req_secure = sec; req_priv = prv;
    #1;
    chk(tag, "req_ready", {31'd0, req_ready}, {31'd0, !e_busy});
    acc = v && !e_busy; ok = sec && prv; sd = r[2]; f = r[1:0];
    e_vld = acc; e_err = acc && !ok; e_rdata = '0;
    if (acc && ok && !w) begin
      if (f == 2'd0) e_rdata = s_word[sd];
      else if (f == 2'd1) e_rdata = {28'd0, s_sb[sd]};
    end
    nb = 1'b0;
    if (e_busy) begin
      s_word[p_side] = p_word; s_sb[p_side] = p_sb;
    end
    if (acc && ok && w) begin
      i = ent(d);
      case (f)
        2'd0: s_word[sd] = d;
        2'd1: s_sb[sd] = d[SBW-1:0];
        2'd2: begin
          m_word[sd][i] = s_word[sd];
          m_hi[sd][i] = s_sb[sd][SBW-1:2];
          m_dty[sd][i/2] = s_sb[sd][1:0];
        end
        default: begin
          nb = 1'b1; p_side = sd; p_word = m_word[sd][i];
          p_sb = {m_hi[sd][i], m_dty[sd][i/2]};
        end
      endcase
    end
    e_busy = nb;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_vld});
    chk(tag, "rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    chk(tag, "busy", {31'd0, busy}, {31'd0, e_busy});
    if (e_vld) chk(tag, "rsp_rdata", rsp_rdata, e_rdata);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [2:0] r, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, r, d, 1'b1, 1'b1);
  endtask

  task automatic rd(input string tag, input logic [2:0] r);
    step(tag, 1'b1, 1'b0, r, 32'd0, 1'b1, 1'b1);
  endtask

  // Write one entry on a side: side base s = 0 (data) or 4 (instruction)
  task automatic put(input string tag, input logic [2:0] s, input logic [31:0] a,
                     input logic [31:0] dw, input logic [3:0] sb);
    wr(tag, s | 3'd0, dw);
    wr(tag, s | 3'd1, {28'd0, sb});
    wr(tag, s | 3'd2, a);
  endtask

  task automatic get(input string tag, input logic [2:0] s, input logic [31:0] a);
    wr(tag, s | 3'd3, a);
    idle(tag);
    rd(tag, s | 3'd0);
    rd(tag, s | 3'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 5000; k++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    e_busy = 0; p_side = 0; p_word = 0; p_sb = 0;
    for (int s = 0; s < 2; s++) begin s_word[s] = '0; s_sb[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    rd("R1", 3'd0); rd("R1", 3'd1); rd("R1", 3'd4); rd("R1", 3'd5);

    // R2: staging registers read back, sideband truncated to SB_W bits
    wr("R2", 3'd0, 32'hCAFE_0001); wr("R2", 3'd1, 32'hFFFF_FFF6);
    wr("R2", 3'd4, 32'h1234_5678); wr("R2", 3'd5, 32'h0000_0009);
    rd("R2", 3'd0); rd("R2", 3'd1); rd("R2", 3'd4); rd("R2", 3'd5);

    // R3/R4: entries spread over every way and several sets
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = {2'(k % 4), 24'd0, 3'(k * 3), 3'(k)};
      put("R3", 3'd0, a, 32'hA500_0000 + 32'(k * 32'h0101_1011), 4'(k + 5));
    end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = {2'(k % 4), 24'd0, 3'(k * 3), 3'(k)};
      get("R4", 3'd0, a);
    end

    // R9: request held while busy is not taken
    wr("R9", 3'd3, {2'd1, 24'd0, 3'd3, 3'd1});
    step("R9", 1'b1, 1'b1, 3'd0, 32'hDEAD_BEEF, 1'b1, 1'b1);
    rd("R9", 3'd0);

    // R5: same address on the instruction side, data side unchanged
    put("R5", 3'd4, {2'd0, 24'd0, 3'd0, 3'd0}, 32'h5555_AAAA, 4'hC);
    get("R5", 3'd0, {2'd0, 24'd0, 3'd0, 3'd0});
    get("R5", 3'd4, {2'd0, 24'd0, 3'd0, 3'd0});

    // R7: doubleword dirty sharing between words 4 and 5
    put("R7", 3'd0, {2'd2, 24'd0, 3'd6, 3'd4}, 32'h0000_0444, 4'b1101);
    put("R7", 3'd0, {2'd2, 24'd0, 3'd6, 3'd5}, 32'h0000_0555, 4'b0110);
    get("R7", 3'd0, {2'd2, 24'd0, 3'd6, 3'd4});
    get("R7", 3'd0, {2'd2, 24'd0, 3'd6, 3'd5});
    put("R7", 3'd4, {2'd3, 24'd0, 3'd7, 3'd3}, 32'h0000_0333, 4'b1011);
    get("R7", 3'd4, {2'd3, 24'd0, 3'd7, 3'd2});

    // R6: denied requests do nothing and report an error
    step("R6", 1'b1, 1'b1, 3'd0, 32'h1111_1111, 1'b0, 1'b1);
    step("R6", 1'b1, 1'b1, 3'd1, 32'h0000_000F, 1'b1, 1'b0);
    step("R6", 1'b1, 1'b0, 3'd0, 32'd0, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b1, 3'd2, {2'd0, 24'd0, 3'd0, 3'd0}, 1'b0, 1'b1);
    step("R6", 1'b1, 1'b1, 3'd3, {2'd1, 24'd0, 3'd3, 3'd1}, 1'b1, 1'b0);
    rd("R6", 3'd0); rd("R6", 3'd1);
    get("R6", 3'd0, {2'd0, 24'd0, 3'd0, 3'd0});

    // R8: command registers read as zero, writes return zero
    rd("R8", 3'd2); rd("R8", 3'd3); rd("R8", 3'd6); rd("R8", 3'd7);
    wr("R8", 3'd4, 32'h7777_0000);
    idle("R8");
    rd("R8", 3'd4);

    finish_run();
  end

endmodule